// File: doc/BRIEF.md
# Zero-Page and Stack Dual-Port Memory Front End

This block sits between an 8-bit processor core with a 16-bit address space and the rest of its memory system. The lowest 512 bytes, which hold the zero page and the stack page, live in an on-chip RAM with two ports. Every other address is forwarded to an external memory interface with a request/acknowledge handshake.

The normal port carries the ordinary address/data bus of the core. It is used for instruction fetch and for general loads and stores, including indexed accesses into the stack page. The fast port is a separate 9-bit address path that the core uses only for zero-page and stack data traffic: loads, stores, pushes, pulls and saved return addresses. It accepts one access in every clock and returns read data one clock later.

Both ports see the same bytes. Code placed in the low 512 bytes can therefore be fetched and modified through the normal port while the fast port pushes and pulls. Any external device decoded into the low 512 bytes is unreachable, because such addresses never leave the chip. A small request state machine controls the normal port. It has four states:
- `ST_IDLE`: waiting for a request.
- `ST_INT_RESP`: an internal access was accepted and its ready is reported.
- `ST_EXT_WAIT`: the external request is held.
- `ST_EXT_RESP`: the external acknowledge arrived and its ready is reported.

The transitions are:
- `ST_IDLE` to `ST_INT_RESP` on an internal request.
- `ST_IDLE` to `ST_EXT_WAIT` on an external request.
- `ST_EXT_WAIT` stays in place until `x_ack`, then moves to `ST_EXT_RESP`.
- Both response states return to `ST_IDLE` after one cycle.
- Reset forces `ST_IDLE`.

Top module: `zsm_front`

## Requirements
- R1: A normal-port request to an address below 0x0200 is served by the internal RAM. `a_ready` is high in the cycle after the request, read data is on `a_rdata` in that cycle, and `x_req` is never asserted for it.
- R2: A normal-port request to an address of 0x0200 or above raises `x_req` in the cycle after the request. `x_addr`, `x_we` and `x_wdata` equal the request and stay stable until `x_ack` is sampled high, and `a_ready` stays low while `x_req` is high.
- R3: In the cycle after `x_ack` is sampled high while `x_req` is high, `x_req` is low and `a_ready` is high for exactly one cycle. For a read, `a_rdata` in that cycle equals the `x_rdata` sampled with the acknowledge.
- R4: The fast port accepts one access in every clock cycle with no stall. Read data for an access (`b_en`=1, `b_we`=0) appears on `b_rdata` in the next cycle, and a write (`b_we`=1) stores `b_wdata` at `b_addr`.
- R5: Both ports address the same storage. A byte written through either port at an offset is read back through the other port at the same offset (normal address = fast address, upper bits zero).
- R6: When both ports write the same byte in the same cycle, the byte afterwards holds the fast-port data.
- R7: A read on one port in the same cycle as a write on the other port to the same byte returns the data being written.
- R8: A normal-port request raised while an earlier request is still in progress is ignored. It changes neither the external request nor the RAM.
- R9: Reset returns the request state machine to idle, so `x_req` and `a_ready` are low after reset, even if reset arrives in the middle of an external access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the request state machine |
| a_req | input | 1 | Normal-port request strobe, one cycle per access |
| a_we | input | 1 | Normal-port write (1) or read (0) |
| a_addr | input | 16 | Normal-port address |
| a_wdata | input | 8 | Normal-port write data |
| a_rdata | output | 8 | Normal-port read data, valid with a_ready |
| a_ready | output | 1 | Normal-port access complete |
| b_en | input | 1 | Fast-port access enable |
| b_we | input | 1 | Fast-port write (1) or read (0) |
| b_addr | input | 9 | Fast-port byte offset in the low 512 bytes |
| b_wdata | input | 8 | Fast-port write data |
| b_rdata | output | 8 | Fast-port read data, one cycle after the access |
| x_req | output | 1 | External access request |
| x_we | output | 1 | External write (1) or read (0) |
| x_addr | output | 16 | External address |
| x_wdata | output | 8 | External write data |
| x_rdata | input | 8 | External read data, valid with x_ack |
| x_ack | input | 1 | External access acknowledge |

## Verification
A stuck or wrong request state shows at the ports within one or two cycles. `a_ready` fails to pulse one cycle after an internal access, or `x_req` rises for a low address, drops before its acknowledge, or stays up after it. A late request that overwrites the latched external address shows as a changed `x_addr` while `x_req` is held. Bad write arbitration or missing forwarding shows as a wrong byte. That byte appears either on the same-cycle read of the opposite port or on a read-back through the other port in the following access.

// File: rtl/zsm_pkg.sv
package zsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_INT_RESP = 2'd1,
        ST_EXT_WAIT = 2'd2,
        ST_EXT_RESP = 2'd3
    } req_state_t;

endpackage

// File: rtl/zsm_decode.sv
module zsm_decode #(
    parameter int ADDR_W = 16,
    parameter int INT_AW = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_int
);
    localparam int HI_W = ADDR_W - INT_AW;

    logic [HI_W-1:0] hi_bits;

    always_comb begin
        hi_bits = addr[ADDR_W-1:INT_AW];
        is_int  = (hi_bits == '0);
    end

endmodule

// File: rtl/zsm_dpram.sv
module zsm_dpram #(
    parameter int DATA_W = 8,
    parameter int INT_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [INT_AW-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wd,
    output logic [DATA_W-1:0] a_q,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [INT_AW-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wd,
    output logic [DATA_W-1:0] b_q
);
    localparam int DEPTH = 1 << INT_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    logic a_wr, b_wr, same;

    always_comb begin
        a_wr = a_en && a_we;
        b_wr = b_en && b_we;
        same = (a_addr == b_addr);
    end

    // storage: fast port wins a same-byte double write
    always_ff @(posedge clk) begin
        if (a_wr && !(b_wr && same)) begin
            mem[a_addr] <= a_wd;
        end
        if (b_wr) begin
            mem[b_addr] <= b_wd;
        end
    end

    // normal-port read register with forwarding
    always_ff @(posedge clk) begin
        if (a_en) begin
            if (b_wr && same) begin
                a_q <= b_wd;
            end else if (a_we) begin
                a_q <= a_wd;
            end else begin
                a_q <= mem[a_addr];
            end
        end
    end

    // fast-port read register with forwarding
    always_ff @(posedge clk) begin
        if (b_en) begin
            if (b_we) begin
                b_q <= b_wd;
            end else if (a_wr && same) begin
                b_q <= a_wd;
            end else begin
                b_q <= mem[b_addr];
            end
        end
    end

    // R7
    fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_we && b_wr && same) |=> (a_q == $past(b_wd)));

    // R7
    fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && !b_we && a_wr && same) |=> (b_q == $past(a_wd)));

endmodule

// File: rtl/zsm_req_fsm.sv
module zsm_req_fsm
    import zsm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              is_int,
    input  logic              x_ack,
    input  logic [DATA_W-1:0] x_rdata,
    output logic              int_fire,
    output logic              a_ready,
    output logic              from_ext,
    output logic [DATA_W-1:0] ext_rdata,
    output logic              x_req,
    output logic              x_we,
    output logic [ADDR_W-1:0] x_addr,
    output logic [DATA_W-1:0] x_wdata
);
    req_state_t state, nstate;

    logic              lat_we;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (a_req) begin
                    nstate = is_int ? ST_INT_RESP : ST_EXT_WAIT;
                end
            end
            ST_INT_RESP: nstate = ST_IDLE;
            ST_EXT_WAIT: begin
                if (x_ack) begin
                    nstate = ST_EXT_RESP;
                end
            end
            ST_EXT_RESP: nstate = ST_IDLE;
            default:     nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // request latch and acknowledge data capture
    always_ff @(posedge clk) begin
        if (state == ST_IDLE && a_req && !is_int) begin
            lat_we    <= a_we;
            lat_addr  <= a_addr;
            lat_wdata <= a_wdata;
        end
        if (state == ST_EXT_WAIT && x_ack) begin
            ext_rdata <= x_rdata;
        end
    end

    always_comb begin
        int_fire = 1'b0;
        a_ready  = 1'b0;
        from_ext = 1'b0;
        x_req    = 1'b0;
        unique case (state)
            ST_IDLE:     int_fire = a_req && is_int;
            ST_INT_RESP: a_ready  = 1'b1;
            ST_EXT_WAIT: x_req    = 1'b1;
            ST_EXT_RESP: begin
                a_ready  = 1'b1;
                from_ext = 1'b1;
            end
            default: ;
        endcase
        x_we    = lat_we;
        x_addr  = lat_addr;
        x_wdata = lat_wdata;
    end

    // R2
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_req && !x_ack) |=> (x_req && $stable(x_addr) && $stable(x_we) && $stable(x_wdata)));

    // R2
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(x_req && a_ready));

    // R3
    ack_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (x_req && x_ack) |=> (a_ready && !x_req));

    // R3
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_ready |=> !a_ready);

    // R1
    int_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_fire |=> (a_ready && !x_req));

endmodule

// File: rtl/zsm_front.sv
module zsm_front #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int INT_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_ready,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [INT_AW-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              x_req,
    output logic              x_we,
    output logic [ADDR_W-1:0] x_addr,
    output logic [DATA_W-1:0] x_wdata,
    input  logic [DATA_W-1:0] x_rdata,
    input  logic              x_ack
);
    logic              is_int;
    logic              int_fire;
    logic              from_ext;
    logic [DATA_W-1:0] ext_rdata;
    logic [DATA_W-1:0] ram_a_q;

    zsm_decode #(.ADDR_W(ADDR_W), .INT_AW(INT_AW)) u_dec (
        .addr   (a_addr),
        .is_int (is_int)
    );

    zsm_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_req     (a_req),
        .a_we      (a_we),
        .a_addr    (a_addr),
        .a_wdata   (a_wdata),
        .is_int    (is_int),
        .x_ack     (x_ack),
        .x_rdata   (x_rdata),
        .int_fire  (int_fire),
        .a_ready   (a_ready),
        .from_ext  (from_ext),
        .ext_rdata (ext_rdata),
        .x_req     (x_req),
        .x_we      (x_we),
        .x_addr    (x_addr),
        .x_wdata   (x_wdata)
    );

    zsm_dpram #(.DATA_W(DATA_W), .INT_AW(INT_AW)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_en   (int_fire),
        .a_we   (a_we),
        .a_addr (a_addr[INT_AW-1:0]),
        .a_wd   (a_wdata),
        .a_q    (ram_a_q),
        .b_en   (b_en),
        .b_we   (b_we),
        .b_addr (b_addr),
        .b_wd   (b_wdata),
        .b_q    (b_rdata)
    );

    always_comb begin
        a_rdata = from_ext ? ext_rdata : ram_a_q;
    end

    // R1
    low_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_req |-> (x_addr[ADDR_W-1:INT_AW] != '0));

endmodule

// File: tb/zsm_front_test.sv
module zsm_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_req = 1'b0, a_we = 1'b0;
    logic [15:0] a_addr = '0;
    logic [7:0]  a_wdata = '0;
    logic [7:0]  a_rdata;
    logic        a_ready;
    logic        b_en = 1'b0, b_we = 1'b0;
    logic [8:0]  b_addr = '0;
    logic [7:0]  b_wdata = '0;
    logic [7:0]  b_rdata;
    logic        x_req, x_we;
    logic [15:0] x_addr;
    logic [7:0]  x_wdata;
    logic [7:0]  x_rdata = '0;
    logic        x_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    zsm_front uut (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_ready(a_ready),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .x_req(x_req), .x_we(x_we), .x_addr(x_addr), .x_wdata(x_wdata),
        .x_rdata(x_rdata), .x_ack(x_ack)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic a_int(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                         output logic [7:0] rd);
        @(negedge clk);
        a_req = 1'b1; a_we = we; a_addr = addr; a_wdata = wd;
        @(negedge clk);
        a_req = 1'b0;
        chk("R1 internal ready", {15'd0, a_ready}, 16'd1);
        chk("R1 no external req", {15'd0, x_req}, 16'd0);
        rd = a_rdata;
        @(negedge clk);
        chk("R1 no external req after", {15'd0, x_req}, 16'd0);
    endtask

    task automatic b_acc(input logic we, input logic [8:0] addr, input logic [7:0] wd,
                         output logic [7:0] rd);
        @(negedge clk);
        b_en = 1'b1; b_we = we; b_addr = addr; b_wdata = wd;
        @(negedge clk);
        b_en = 1'b0; b_we = 1'b0;
        rd = b_rdata;
    endtask

    task automatic ext_acc(input logic we, input logic [15:0] addr, input logic [7:0] wd,
                           input logic [7:0] ackd, input int waitn);
        @(negedge clk);
        a_req = 1'b1; a_we = we; a_addr = addr; a_wdata = wd;
        @(negedge clk);
        a_req = 1'b0; a_addr = 16'h0000; a_wdata = 8'h00;
        for (int i = 0; i <= waitn; i++) begin
            chk("R2 x_req held", {15'd0, x_req}, 16'd1);
            chk("R2 x_addr", x_addr, addr);
            chk("R2 x_we", {15'd0, x_we}, {15'd0, we});
            if (we) chk("R2 x_wdata", {8'd0, x_wdata}, {8'd0, wd});
            chk("R2 ready low while waiting", {15'd0, a_ready}, 16'd0);
            if (i < waitn) @(negedge clk);
        end
        x_ack = 1'b1; x_rdata = ackd;
        @(negedge clk);
        x_ack = 1'b0; x_rdata = 8'h00;
        chk("R3 ready after ack", {15'd0, a_ready}, 16'd1);
        chk("R3 x_req dropped", {15'd0, x_req}, 16'd0);
        if (!we) chk("R3 read data", {8'd0, a_rdata}, {8'd0, ackd});
        @(negedge clk);
        chk("R3 ready one cycle", {15'd0, a_ready}, 16'd0);
    endtask

    task automatic t_reset();
        chk("R9 x_req in reset", {15'd0, x_req}, 16'd0);
        chk("R9 ready in reset", {15'd0, a_ready}, 16'd0);
    endtask

    task automatic t_shared();
        logic [7:0] r;
        a_int(1'b1, 16'h0105, 8'h3C, r);
        b_acc(1'b0, 9'h105, 8'h00, r);
        chk("R5 normal write fast read", {8'd0, r}, 16'h003C);
        b_acc(1'b1, 9'h1FF, 8'hA7, r);
        a_int(1'b0, 16'h01FF, 8'h00, r);
        chk("R5 fast write normal read top byte", {8'd0, r}, 16'h00A7);
        b_acc(1'b1, 9'h000, 8'h5E, r);
        a_int(1'b0, 16'h0000, 8'h00, r);
        chk("R5 fast write normal read byte 0", {8'd0, r}, 16'h005E);
    endtask

    task automatic t_burst();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            b_en = 1'b1; b_we = 1'b1; b_addr = 9'h010 + 9'(i); b_wdata = 8'hC0 + 8'(i);
            @(negedge clk);
        end
        b_we = 1'b0; b_addr = 9'h010;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R4 back-to-back read", {8'd0, b_rdata}, {8'd0, 8'hC0 + 8'(i)});
            b_addr = 9'h011 + 9'(i);
        end
        b_en = 1'b0;
    endtask

    task automatic t_collide();
        logic [7:0] r;
        @(negedge clk);
        a_req = 1'b1; a_we = 1'b1; a_addr = 16'h0080; a_wdata = 8'h11;
        b_en = 1'b1; b_we = 1'b1; b_addr = 9'h080; b_wdata = 8'h22;
        @(negedge clk);
        a_req = 1'b0; b_en = 1'b0; b_we = 1'b0;
        chk("R1 ready on collision", {15'd0, a_ready}, 16'd1);
        a_int(1'b0, 16'h0080, 8'h00, r);
        chk("R6 fast port wins", {8'd0, r}, 16'h0022);
    endtask

    task automatic t_forward();
        logic [7:0] r;
        b_acc(1'b1, 9'h090, 8'h01, r);
        @(negedge clk);
        a_req = 1'b1; a_we = 1'b0; a_addr = 16'h0090;
        b_en = 1'b1; b_we = 1'b1; b_addr = 9'h090; b_wdata = 8'h5A;
        @(negedge clk);
        a_req = 1'b0; b_en = 1'b0; b_we = 1'b0;
        chk("R7 normal read sees fast write", {8'd0, a_rdata}, 16'h005A);
        b_acc(1'b1, 9'h091, 8'h02, r);
        @(negedge clk);
        a_req = 1'b1; a_we = 1'b1; a_addr = 16'h0091; a_wdata = 8'h6B;
        b_en = 1'b1; b_we = 1'b0; b_addr = 9'h091;
        @(negedge clk);
        a_req = 1'b0; b_en = 1'b0;
        chk("R7 fast read sees normal write", {8'd0, b_rdata}, 16'h006B);
    endtask

    task automatic t_busy();
        logic [7:0] r;
        b_acc(1'b1, 9'h042, 8'h01, r);
        @(negedge clk);
        a_req = 1'b1; a_we = 1'b0; a_addr = 16'h9000;
        @(negedge clk);
        a_req = 1'b1; a_we = 1'b1; a_addr = 16'h0042; a_wdata = 8'h99;
        @(negedge clk);
        a_req = 1'b0; a_we = 1'b0;
        chk("R8 x_addr unchanged", x_addr, 16'h9000);
        chk("R8 x_we unchanged", {15'd0, x_we}, 16'd0);
        chk("R8 still waiting", {15'd0, x_req}, 16'd1);
        x_ack = 1'b1; x_rdata = 8'h4D;
        @(negedge clk);
        x_ack = 1'b0;
        chk("R8 first request data", {8'd0, a_rdata}, 16'h004D);
        b_acc(1'b0, 9'h042, 8'h00, r);
        chk("R8 RAM untouched", {8'd0, r}, 16'h0001);
    endtask

    task automatic t_low_no_ext();
        logic [7:0] r;
        a_int(1'b1, 16'h01F0, 8'hEE, r);
        a_int(1'b0, 16'h01F0, 8'h00, r);
        chk("R1 low address read local", {8'd0, r}, 16'h00EE);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        a_req = 1'b1; a_we = 1'b0; a_addr = 16'hFFFF;
        @(negedge clk);
        a_req = 1'b0;
        chk("R2 request up before reset", {15'd0, x_req}, 16'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 x_req cleared", {15'd0, x_req}, 16'd0);
        chk("R9 ready cleared", {15'd0, a_ready}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after release", {15'd0, x_req}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_shared();
        t_burst();
        t_collide();
        t_forward();
        ext_acc(1'b0, 16'h8000, 8'h00, 8'hD2, 3);
        ext_acc(1'b1, 16'h0200, 8'h77, 8'h00, 0);
        t_busy();
        t_low_no_ext();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule